// File: doc/BRIEF.md
# Clearing-Window Load/Store Gate

This block sits between a core's load/store stage and its single memory port while a background engine clears a stack region from the top downward. The region not yet cleared is the window from a fixed bottom address up to the engine's moving top. Any core access into that window must not reach memory until the engine has cleared the word it touches. The gate holds such an access back, or drops it if an interrupt arrives first. It lets the clearing engine's stores use the port in every cycle the core is not issuing.

When no clear is running, accesses pass straight through in the cycle they are requested. While a clear runs, every access takes a forced first stall cycle, and the window test happens in a register stage. This keeps the combinational stall decision that fans out into the pipeline down to two inputs. An access found in the window keeps stalling until the top drops to or below its word. If an interrupt arrives first, the access is dropped and a restart flag tells the exception logic to save the address of this same instruction. Two counters record the stall cycles, one for loads and one for stores. A hold output suspends any other background memory scanner while a clear is running.

Top module: `clrwin_gate`

## Requirements
- R1: With `clr_active` low and no access pending a window decision, a core request is issued to memory in the same cycle (`mem_req`=1, `mem_we`/`mem_addr`/`mem_wdata` from the core) with `core_gnt`=1 and `core_stall`=0, whatever its address.
- R2: With `clr_active` high, the first cycle of every core request gives `core_stall`=1 and `core_gnt`=0, and no core access is issued in that cycle.
- R3: The window test uses word addresses (address bits above log2(`WORD_BYTES`)): an access is inside the window when bottom ≤ address < top. An access that is outside the window in its first cycle is issued in its second cycle.
- R4: A store inside the window stalls. It is issued one cycle after the first cycle in which the top, compared at word level, is at or below the store's word.
- R5: A load inside the window stalls in the same way as a store, and no memory request is made for it while it stalls.
- R6: If `irq` is high in a cycle where an access is stalled on a window hit, `core_abort` and `core_restart` pulse high for that one cycle. `core_gnt` stays low and the access is never issued. In any other cycle, `irq` has no effect on the access.
- R7: When `eng_req` is high and no core access is being issued, `eng_gnt`=1 and memory gets a write of `eng_addr`/`eng_wdata`. In a cycle where the core access is issued, `eng_gnt`=0.
- R8: `scan_hold` equals `clr_active`.
- R9: `ld_stall_cnt` and `st_stall_cnt` start at zero after reset. Each one increases by one in every cycle where `core_stall` is high for a load (`core_we`=0) or a store (`core_we`=1) respectively, and wraps at its width.
- R10: In reset, and with no requests, `core_gnt`, `core_stall`, `core_abort` and `mem_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_active | input | 1 | Background clear in progress |
| clr_bottom | input | AW | Lowest byte address of the uncleared window |
| clr_top | input | AW | Engine's current top (exclusive) |
| irq | input | 1 | Interrupt pending towards the core |
| core_req | input | 1 | Core access request, held until granted or aborted |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | AW | Core byte address |
| core_wdata | input | DW | Core store data |
| core_gnt | output | 1 | Core access issued this cycle |
| core_stall | output | 1 | Core access held this cycle |
| core_abort | output | 1 | Core access dropped for an interrupt |
| core_restart | output | 1 | Saved program counter must point at this instruction |
| eng_req | input | 1 | Clearing engine store request |
| eng_addr | input | AW | Clearing engine store address |
| eng_wdata | input | DW | Clearing engine store data |
| eng_gnt | output | 1 | Engine store issued this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| scan_hold | output | 1 | Suspend other background scanners |
| ld_stall_cnt | output | CNT_W | Load stall cycle count |
| st_stall_cnt | output | CNT_W | Store stall cycle count |

## Verification
If the registered hit flag stuck high, a stalled access would never be granted and the engine's top could move with no effect. If it stuck low, an access into the window would reach `mem_req` on its second cycle, one cycle after it was presented. A phase register left in the check state would show on the next idle-path request as a missing same-cycle grant. A counter that misses or doubles a cycle differs from the stall count at the end of that same access, because each access's latency fixes exactly how many stall cycles it should add.

// File: rtl/clrwin_pkg.sv
// Package: shared types for the clearing-window gate.
// Assumes nothing beyond IEEE 1800-2017.
package clrwin_pkg;
    // Phase of the access currently presented by the core.
    typedef enum logic {
        PH_IDLE  = 1'b0,   // no access under window decision
        PH_CHECK = 1'b1    // registered window result is valid
    } gate_phase_e;
endpackage

// File: rtl/clrwin_window_cmp.sv
// Module: clrwin_window_cmp
// Combinational window test: hit when bottom <= addr < top, with all three
// reduced to word addresses. Assumes bottom and top are byte addresses and
// that WORD_BYTES is a power of two.
module clrwin_window_cmp #(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] bottom,
    input  logic [AW-1:0] top,
    output logic          hit
);
    localparam int OFF = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;
    localparam int WW  = AW - OFF;

    logic [WW-1:0] a_w, b_w, t_w;

    // Drop byte-offset bits and compare the word numbers.
    always_comb begin
        a_w = addr[AW-1:OFF];
        b_w = bottom[AW-1:OFF];
        t_w = top[AW-1:OFF];
        hit = (a_w >= b_w) && (a_w < t_w);
    end
endmodule

// File: rtl/clrwin_stall_fsm.sv
// Module: clrwin_stall_fsm
// Decides per cycle whether the presented core access is issued, stalled or
// dropped. The first-cycle decision uses only clr_active and the request; the
// window hit is registered for the following cycles. Assumes the core holds
// its request and address stable until issued or aborted.
module clrwin_stall_fsm
    import clrwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_active,
    input  logic core_req,
    input  logic hit_now,
    input  logic irq,
    output logic core_issue,
    output logic core_abort,
    output logic core_stall,
    output logic busy
);
    gate_phase_e phase_q, phase_d;
    logic        hit_q;

    // Issue / abort / stall decision for the current cycle.
    always_comb begin
        core_issue = 1'b0;
        core_abort = 1'b0;
        if (core_req) begin
            if (phase_q == PH_IDLE) begin
                core_issue = !clr_active;
            end else if (!hit_q) begin
                core_issue = 1'b1;
            end else begin
                core_abort = irq;
            end
        end
        core_stall = core_req && !core_issue && !core_abort;
        busy       = (phase_q == PH_CHECK);
    end

    // Next phase: enter the check phase after a stalled first cycle.
    always_comb begin
        phase_d = phase_q;
        if (phase_q == PH_IDLE) begin
            if (core_req && clr_active) phase_d = PH_CHECK;
        end else if (core_issue || core_abort || !core_req) begin
            phase_d = PH_IDLE;
        end
    end

    // Phase register and registered window result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            hit_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            hit_q   <= clr_active && hit_now;
        end
    end

    // R6: a dropped access leaves the check phase at once
    abort_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_abort |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/clrwin_port_arb.sv
// Module: clrwin_port_arb
// Shares the single memory port: a core access being issued wins; the
// clearing engine's store uses every other cycle it asks for.
module clrwin_port_arb #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_issue,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    input  logic          eng_req,
    input  logic [AW-1:0] eng_addr,
    input  logic [DW-1:0] eng_wdata,
    output logic          eng_gnt,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    // Port multiplexer with fixed priority for the core.
    always_comb begin
        eng_gnt = eng_req && !core_issue;
        mem_req = core_issue || eng_gnt;
        if (core_issue) begin
            mem_we    = core_we;
            mem_addr  = core_addr;
            mem_wdata = core_wdata;
        end else begin
            mem_we    = eng_gnt;
            mem_addr  = eng_gnt ? eng_addr  : '0;
            mem_wdata = eng_gnt ? eng_wdata : '0;
        end
    end

    // R7
    eng_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_gnt |-> (mem_req && mem_we && mem_addr == eng_addr));
endmodule

// File: rtl/clrwin_perf_cnt.sv
// Module: clrwin_perf_cnt
// Two wrapping counters of stall cycles, split by access direction.
module clrwin_perf_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             we,
    output logic [CNT_W-1:0] ld_cnt,
    output logic [CNT_W-1:0] st_cnt
);
    // Count one per stalled cycle into the counter for its direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_cnt <= '0;
            st_cnt <= '0;
        end else if (stall) begin
            if (we) st_cnt <= st_cnt + 1'b1;
            else    ld_cnt <= ld_cnt + 1'b1;
        end
    end

    // R9
    ld_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !we) |=> (ld_cnt == $past(ld_cnt) + 1'b1));
    // R9
    st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> $stable(st_cnt));
endmodule

// File: rtl/clrwin_gate.sv
// Module: clrwin_gate (top)
// Gates core loads/stores against the uncleared window of a background
// stack clear and shares one memory port with the clearing engine.
// Assumes: the core holds a request until core_gnt or core_abort, and the
// engine's top only moves downward while clr_active is high.
module clrwin_gate #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_active,
    input  logic [AW-1:0]    clr_bottom,
    input  logic [AW-1:0]    clr_top,
    input  logic             irq,
    input  logic             core_req,
    input  logic             core_we,
    input  logic [AW-1:0]    core_addr,
    input  logic [DW-1:0]    core_wdata,
    output logic             core_gnt,
    output logic             core_stall,
    output logic             core_abort,
    output logic             core_restart,
    input  logic             eng_req,
    input  logic [AW-1:0]    eng_addr,
    input  logic [DW-1:0]    eng_wdata,
    output logic             eng_gnt,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             scan_hold,
    output logic [CNT_W-1:0] ld_stall_cnt,
    output logic [CNT_W-1:0] st_stall_cnt
);
    logic win_hit;
    logic core_issue;
    logic busy;

    clrwin_window_cmp #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_cmp (
        .addr(core_addr), .bottom(clr_bottom), .top(clr_top), .hit(win_hit)
    );

    clrwin_stall_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clr_active(clr_active),
        .core_req(core_req), .hit_now(win_hit), .irq(irq),
        .core_issue(core_issue), .core_abort(core_abort),
        .core_stall(core_stall), .busy(busy)
    );

    clrwin_port_arb #(.AW(AW), .DW(DW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .core_issue(core_issue), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .eng_req(eng_req), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
        .eng_gnt(eng_gnt), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    clrwin_perf_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .stall(core_stall), .we(core_we),
        .ld_cnt(ld_stall_cnt), .st_cnt(st_stall_cnt)
    );

    // Grant, restart flag and scanner hold at the core-facing edge.
    always_comb begin
        core_gnt     = core_issue;
        core_restart = core_abort;
        scan_hold    = clr_active;
    end

    // R1
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && !clr_active && !busy) |-> (core_gnt && mem_req));
    // R2
    first_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && clr_active && !busy) |-> (core_stall && !core_gnt));
    // R5
    no_hit_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_gnt && busy) |-> !$past(clr_active && win_hit));
    // R6
    abort_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_abort |-> (!core_gnt && core_restart && !core_stall));
endmodule

// File: tb/test_clrwin_gate.sv
`timescale 1ns/1ps
module test_clrwin_gate;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_active = 1'b0;
    logic [AW-1:0] clr_bottom = '0, clr_top = '0;
    logic irq = 1'b0;
    logic core_req = 1'b0, core_we = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic core_gnt, core_stall, core_abort, core_restart;
    logic eng_req = 1'b0;
    logic [AW-1:0] eng_addr = '0;
    logic [DW-1:0] eng_wdata = '0;
    logic eng_gnt, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic scan_hold;
    logic [CW-1:0] ld_stall_cnt, st_stall_cnt;

    int n_chk = 0;
    int n_err = 0;
    int exp_ld = 0;
    int exp_st = 0;
    bit done = 1'b0;

    typedef struct {
        bit          abort;
        bit          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #2.5 clk = ~clk;

    clrwin_gate #(.AW(AW), .DW(DW), .WORD_BYTES(4), .CNT_W(CW)) i_clrwin_gate (
        .clk(clk), .rst_n(rst_n), .clr_active(clr_active),
        .clr_bottom(clr_bottom), .clr_top(clr_top), .irq(irq),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_gnt(core_gnt), .core_stall(core_stall),
        .core_abort(core_abort), .core_restart(core_restart),
        .eng_req(eng_req), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
        .eng_gnt(eng_gnt), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .scan_hold(scan_hold),
        .ld_stall_cnt(ld_stall_cnt), .st_stall_cnt(st_stall_cnt)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Monitor: pops the expected outcome whenever the core access resolves.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && (core_gnt || core_abort)) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected core outcome", core_gnt, 0);
                end else begin
                    exp_item_t e;
                    e = sb_q.pop_front();
                    check(core_abort == e.abort, e.tag, "abort vs issue", core_abort, e.abort);
                    if (e.abort) begin
                        check(core_restart && !core_gnt, e.tag, "restart flag", core_restart, 1);
                    end else begin
                        check(mem_req && mem_we == e.we && mem_addr == e.addr &&
                              (!e.we || mem_wdata == e.data),
                              e.tag, "memory issue addr", mem_addr, e.addr);
                    end
                end
            end
        end
    end

    // Driver: presents one access, moves the top or raises irq on chosen
    // cycles, pushes the expected outcome and checks latency and counters.
    task automatic access(input bit we, input logic [AW-1:0] addr,
                          input int irq_at, input int move_at,
                          input logic [AW-1:0] new_top,
                          input bit exp_abort, input int exp_cyc, input string tag);
        exp_item_t e;
        int cyc = 0;
        bit fin = 1'b0;
        e.abort = exp_abort; e.we = we; e.addr = addr;
        e.data = 32'hA500_0000 | addr; e.tag = tag;
        sb_q.push_back(e);
        for (int k = 0; k < 60 && !fin; k++) begin
            @(negedge clk);
            core_req = 1'b1; core_we = we; core_addr = addr;
            core_wdata = e.data;
            irq = (k == irq_at);
            if (k == move_at) clr_top = new_top;
            #1;
            cyc = k + 1;
            if (eng_req)
                check(eng_gnt == !core_gnt && (core_gnt || mem_addr == eng_addr),
                      "R7", "engine grant", eng_gnt, !core_gnt);
            if (core_stall && k > 0 && exp_abort == 1'b0 && cyc < exp_cyc)
                check(!core_gnt, tag, "held while stalled", core_gnt, 0);
            fin = core_gnt || core_abort;
        end
        @(negedge clk);
        core_req = 1'b0; irq = 1'b0;
        #1;
        check(cyc == exp_cyc, tag, "cycles to resolve", cyc, exp_cyc);
        if (we) exp_st += exp_cyc - 1;
        else    exp_ld += exp_cyc - 1;
        check(ld_stall_cnt == CW'(exp_ld), "R9", "load stall count", ld_stall_cnt, exp_ld);
        check(st_stall_cnt == CW'(exp_st), "R9", "store stall count", st_stall_cnt, exp_st);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 0, 1);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        check(!core_gnt && !core_stall && !core_abort && !mem_req, "R10",
              "outputs in reset", {core_gnt, core_stall, core_abort, mem_req}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(ld_stall_cnt == 0 && st_stall_cnt == 0, "R10", "counters after reset",
              ld_stall_cnt + st_stall_cnt, 0);
        check(scan_hold == 1'b0, "R8", "scan_hold idle", scan_hold, 0);

        // R1: no clear running, single-cycle pass even inside the later window
        clr_bottom = 32'h100; clr_top = 32'h200;
        access(1'b0, 32'h0000_0180, -1, -1, '0, 1'b0, 1, "R1");
        access(1'b1, 32'h0000_0044, 0, -1, '0, 1'b0, 1, "R1");

        // Clear starts; engine store stream present
        clr_active = 1'b1; eng_req = 1'b1;
        eng_addr = 32'h1FC; eng_wdata = '0;
        @(negedge clk); #1;
        check(scan_hold == 1'b1, "R8", "scan_hold active", scan_hold, 1);

        // R2/R3: misses take exactly two cycles
        access(1'b0, 32'h0000_0300, -1, -1, '0, 1'b0, 2, "R2");
        access(1'b1, 32'h0000_0200, -1, -1, '0, 1'b0, 2, "R3");
        access(1'b1, 32'h0000_00FC, -1, -1, '0, 1'b0, 2, "R3");
        // R6: irq on a non-window stall is ignored
        access(1'b0, 32'h0000_0400, 1, -1, '0, 1'b0, 2, "R6");

        // R5: load at the bottom word stalls until top moves down at cycle 3
        access(1'b0, 32'h0000_0101, -1, 3, 32'h0000_0100, 1'b0, 5, "R5");
        clr_top = 32'h200;

        // R4: unaligned store in the top word; top passes it at cycle 2
        access(1'b1, 32'h0000_01FF, -1, 2, 32'h0000_01FC, 1'b0, 4, "R4");
        clr_top = 32'h200;

        // R6: interrupts during window stalls drop the access
        access(1'b1, 32'h0000_0150, 2, -1, '0, 1'b1, 3, "R6");
        access(1'b0, 32'h0000_0180, 1, -1, '0, 1'b1, 2, "R6");

        // R6: nothing issued for the dropped access afterwards
        eng_req = 1'b0;
        @(negedge clk); #1;
        check(!mem_req && !core_gnt, "R6", "no late issue", mem_req, 0);
        check(sb_q.size() == 0, "R5", "scoreboard drained", sb_q.size(), 0);

        done = 1'b1;
        summary();
    end
endmodule